// File: doc/BRIEF.md
# Dual-Slot Narrow-Width Line Datapath

This block is the steering logic that sits around a small array of 64-bit wordlines. Each line holds either one full-width value or up to two 32-bit narrow values. A per-line mode (a valid bit plus two flag bits) records how the line is packed. The block uses the mode to pick where incoming data lands and how stored data reaches the read bus. It also drives separate enables for the low and high 32-bit halves, so a half access touches only one half of the wordline.

A single request port carries the address, an operation code, the requester kind (processor or lower-level cache) and a word select. Any value whose upper 32 bits are zero counts as narrow; this is decided combinationally from the write data.

The two narrow slots of a line fill in turn: the first narrow value goes where the word select points, and the second goes to whichever half is still free. A lower-level cache can move a packed pair in a single full-width access. Read data is registered and comes out one cycle after the request.

Top module: `nwl_line_datapath`

## Requirements
- R1: After reset every line is empty and `rd_valid` is low. A read of an empty line returns zero on `rd_data` and asserts no half enable.
- R2: A `req_op`=2'b01 write whose data has a nonzero bit in [63:32] stores all 64 bits and asserts both write enables. The line's mode becomes wide: half flag 0, upper flag 0.
- R3: A read of a wide line returns {high half, low half} unchanged and asserts both read enables, for either requester.
- R4: A narrow write to an empty or wide line stores data[31:0] in the half named by `req_word` (0 low, 1 high). Only that half's write enable is asserted, and the mode becomes half-low (flags 1,0) or half-high (flags 1,1).
- R5: A read of a half-low line returns {32'b0, low half}. A read of a half-high line returns {32'b0, high half}, with the high half moved onto bits [31:0]. Only the occupied half's read enable is asserted.
- R6: A narrow write to a half-low or half-high line stores data[31:0] in the free half, whatever `req_word` is. It asserts only that half's write enable, and the mode becomes pair (flags 0,1).
- R7: A read of a pair line by the processor (`req_src`=0) returns the word named by `req_word`, zero-extended, with only that half's read enable. A read by the lower-level cache (`req_src`=1) returns {high, low} with both read enables.
- R8: A narrow write to a pair line replaces the half named by `req_word` and asserts only its write enable. The line stays in pair mode and the other word is kept.
- R9: A `req_op`=2'b10 paired write stores all 64 bits in one access with both write enables, and puts the line in pair mode.
- R10: While `req_valid` is low, or `req_op` is 2'b11, no half enable is asserted, no line changes and `rd_valid` stays low.
- R11: `req_op`=2'b00 is a read. `rd_valid` and `rd_data` update on the clock edge that ends a read request cycle, and `rd_valid` is low after any other cycle. A write is visible to a read issued in the next cycle.
- R12: An access changes only the line selected by `req_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, empties every line |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 write, 10 paired write, 11 no access |
| req_src | input | 1 | 0 processor, 1 lower-level cache |
| req_word | input | 1 | Word select: 0 low half, 1 high half |
| req_idx | input | 3 | Line index |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| wen_lo | output | 1 | Write enable, low half |
| wen_hi | output | 1 | Write enable, high half |
| ren_lo | output | 1 | Read enable, low half |
| ren_hi | output | 1 | Read enable, high half |

## Verification
The bench starts from each line state: empty, wide, half-low, half-high and pair. From each it applies every request kind, then reads the line back three ways and probes a neighbouring line.

**Narrow boundary.** The data includes values that sit on the narrow boundary: all ones in the low word, and a value whose only set bit is bit 32. A detector that tested the wrong bits would store that second value as narrow and lose bit 32.

**Slot selection.** A second narrow write that obeyed `req_word` instead of picking the free half would overwrite the first value. A half-high read that failed to shift would put the data on bits [63:32].

**Read steering.** Pair reads are checked for both requester kinds. A design that ignored the requester would give the processor both words, or give the lower-level cache only one.

// File: rtl/nwl_pkg.sv
package nwl_pkg;

    // Request operation codes on req_op
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_PAIR  = 2'b10,
        OP_IDLE  = 2'b11
    } nwl_op_e;

    // Per-line packing state: half=1 -> one narrow value, upper selects its half;
    // half=0 -> full line, upper=1 means two packed narrow values.
    typedef struct packed {
        logic valid;
        logic half;
        logic upper;
    } nwl_mode_t;

endpackage

// File: rtl/nwl_line_array.sv
module nwl_line_array
    import nwl_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int WORD_W = 32,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wen_lo,
    input  logic              wen_hi,
    input  logic [WORD_W-1:0] wr_lo,
    input  logic [WORD_W-1:0] wr_hi,
    input  logic              mode_we,
    input  nwl_mode_t         mode_in,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi,
    output nwl_mode_t         mode_out
);

    typedef struct packed {
        nwl_mode_t         mode;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } entry_t;

    entry_t [LINES-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wen_lo) begin
            ent_d[idx].lo = wr_lo;
        end
        if (wen_hi) begin
            ent_d[idx].hi = wr_hi;
        end
        if (mode_we) begin
            ent_d[idx].mode = mode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_lo    = ent_q[idx].lo;
    assign rd_hi    = ent_q[idx].hi;
    assign mode_out = ent_q[idx].mode;

endmodule

// File: rtl/nwl_write_steer.sv
module nwl_write_steer
    import nwl_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int LINE_W = 2 * WORD_W
) (
    input  logic              is_write,
    input  logic              is_pair,
    input  logic              word_sel,
    input  nwl_mode_t         cur,
    input  logic [LINE_W-1:0] wdata,
    output logic              wen_lo,
    output logic              wen_hi,
    output logic              mode_we,
    output nwl_mode_t         mode_nx,
    output logic [WORD_W-1:0] wr_lo,
    output logic [WORD_W-1:0] wr_hi
);

    logic narrow;
    logic place_hi;

    assign narrow = ~|wdata[LINE_W-1:WORD_W];

    always_comb begin
        wen_lo   = 1'b0;
        wen_hi   = 1'b0;
        mode_we  = 1'b0;
        mode_nx  = cur;
        place_hi = 1'b0;
        wr_lo    = wdata[WORD_W-1:0];
        wr_hi    = wdata[LINE_W-1:WORD_W];
        if (is_pair) begin
            wen_lo  = 1'b1;
            wen_hi  = 1'b1;
            mode_we = 1'b1;
            mode_nx = '{valid: 1'b1, half: 1'b0, upper: 1'b1};
        end else if (is_write && !narrow) begin
            wen_lo  = 1'b1;
            wen_hi  = 1'b1;
            mode_we = 1'b1;
            mode_nx = '{valid: 1'b1, half: 1'b0, upper: 1'b0};
        end else if (is_write) begin
            mode_we = 1'b1;
            wr_hi   = wdata[WORD_W-1:0];
            if (!cur.valid || (!cur.half && !cur.upper)) begin
                place_hi = word_sel;
                mode_nx  = '{valid: 1'b1, half: 1'b1, upper: word_sel};
            end else if (cur.half) begin
                place_hi = ~cur.upper;
                mode_nx  = '{valid: 1'b1, half: 1'b0, upper: 1'b1};
            end else begin
                place_hi = word_sel;
                mode_nx  = '{valid: 1'b1, half: 1'b0, upper: 1'b1};
            end
            wen_hi = place_hi;
            wen_lo = ~place_hi;
        end
    end

endmodule

// File: rtl/nwl_read_steer.sv
module nwl_read_steer
    import nwl_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int LINE_W = 2 * WORD_W
) (
    input  logic              is_read,
    input  logic              from_lower,
    input  logic              word_sel,
    input  nwl_mode_t         cur,
    input  logic [WORD_W-1:0] line_lo,
    input  logic [WORD_W-1:0] line_hi,
    output logic              ren_lo,
    output logic              ren_hi,
    output logic [LINE_W-1:0] rdata
);

    localparam logic [WORD_W-1:0] ZW = '0;

    always_comb begin
        ren_lo = 1'b0;
        ren_hi = 1'b0;
        rdata  = '0;
        if (is_read && cur.valid) begin
            unique case ({cur.half, cur.upper})
                2'b00: begin
                    ren_lo = 1'b1;
                    ren_hi = 1'b1;
                    rdata  = {line_hi, line_lo};
                end
                2'b10: begin
                    ren_lo = 1'b1;
                    rdata  = {ZW, line_lo};
                end
                2'b11: begin
                    ren_hi = 1'b1;
                    rdata  = {ZW, line_hi};
                end
                default: begin
                    if (from_lower) begin
                        ren_lo = 1'b1;
                        ren_hi = 1'b1;
                        rdata  = {line_hi, line_lo};
                    end else if (word_sel) begin
                        ren_hi = 1'b1;
                        rdata  = {ZW, line_hi};
                    end else begin
                        ren_lo = 1'b1;
                        rdata  = {ZW, line_lo};
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/nwl_line_datapath.sv
module nwl_line_datapath
    import nwl_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int WORD_W = 32,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int LINE_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_src,
    input  logic              req_word,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [LINE_W-1:0] wr_data,
    output logic [LINE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              wen_lo,
    output logic              wen_hi,
    output logic              ren_lo,
    output logic              ren_hi
);

    typedef struct packed {
        logic              rvalid;
        logic [LINE_W-1:0] rdata;
    } rd_reg_t;

    logic              is_read, is_write, is_pair;
    nwl_mode_t         cur_mode, mode_nx;
    logic              mode_we;
    logic [WORD_W-1:0] line_lo, line_hi, wr_lo, wr_hi;
    logic [LINE_W-1:0] steer_rdata;
    logic              cur_valid, cur_half;
    rd_reg_t           rd_d, rd_q;

    assign is_read  = req_valid && (req_op == OP_READ);
    assign is_write = req_valid && (req_op == OP_WRITE);
    assign is_pair  = req_valid && (req_op == OP_PAIR);

    assign cur_valid = cur_mode.valid;
    assign cur_half  = cur_mode.half;

    nwl_line_array #(.LINES(LINES), .WORD_W(WORD_W)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .wen_lo   (wen_lo),
        .wen_hi   (wen_hi),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .mode_we  (mode_we),
        .mode_in  (mode_nx),
        .rd_lo    (line_lo),
        .rd_hi    (line_hi),
        .mode_out (cur_mode)
    );

    nwl_write_steer #(.WORD_W(WORD_W)) wsteer_i (
        .is_write (is_write),
        .is_pair  (is_pair),
        .word_sel (req_word),
        .cur      (cur_mode),
        .wdata    (wr_data),
        .wen_lo   (wen_lo),
        .wen_hi   (wen_hi),
        .mode_we  (mode_we),
        .mode_nx  (mode_nx),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi)
    );

    nwl_read_steer #(.WORD_W(WORD_W)) rsteer_i (
        .is_read    (is_read),
        .from_lower (req_src),
        .word_sel   (req_word),
        .cur        (cur_mode),
        .line_lo    (line_lo),
        .line_hi    (line_hi),
        .ren_lo     (ren_lo),
        .ren_hi     (ren_hi),
        .rdata      (steer_rdata)
    );

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = is_read;
        if (is_read) begin
            rd_d.rdata = steer_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data  = rd_q.rdata;
    assign rd_valid = rd_q.rvalid;

endmodule

// File: rtl/nwl_line_datapath_chk.sv
module nwl_line_datapath_chk #(
    parameter int WORD_W = 32,
    localparam int LINE_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [LINE_W-1:0] wr_data,
    input logic [LINE_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              wen_lo,
    input logic              wen_hi,
    input logic              ren_lo,
    input logic              ren_hi,
    input logic              cur_valid,
    input logic              cur_half
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_op == 2'b11) |-> !(wen_lo || wen_hi || ren_lo || ren_hi));

    // R11
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00) |=> rd_valid);

    // R11
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op == 2'b00) |=> !rd_valid);

    // R2
    wide_both_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && (|wr_data[LINE_W-1:WORD_W])) |-> (wen_lo && wen_hi));

    // R4
    narrow_single_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && !(|wr_data[LINE_W-1:WORD_W]))
            |-> ($countones({wen_hi, wen_lo}) == 1));

    // R5
    half_read_one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00 && cur_valid && cur_half)
            |-> ($countones({ren_hi, ren_lo}) == 1));

    // R5
    half_read_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00 && cur_valid && cur_half)
            |=> (rd_data[LINE_W-1:WORD_W] == '0));

    // R9
    pair_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10) |-> (wen_lo && wen_hi && !ren_lo && !ren_hi));

endmodule

bind nwl_line_datapath nwl_line_datapath_chk #(.WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .wen_lo    (wen_lo),
    .wen_hi    (wen_hi),
    .ren_lo    (ren_lo),
    .ren_hi    (ren_hi),
    .cur_valid (cur_valid),
    .cur_half  (cur_half)
);

// File: tb/nwl_line_datapath_tb.sv
`timescale 1ns/1ps
module nwl_line_datapath_tb_top;

    localparam int LINES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b11;
    logic        req_src = 1'b0;
    logic        req_word = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic        wen_lo, wen_hi, ren_lo, ren_hi;

    int n_checks = 0;
    int n_err = 0;

    bit          m_valid [LINES];
    bit          m_half  [LINES];
    bit          m_upper [LINES];
    logic [31:0] m_lo    [LINES];
    logic [31:0] m_hi    [LINES];

    always #2.5 clk = ~clk;

    nwl_line_datapath #(.LINES(LINES), .WORD_W(32)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_src   (req_src),
        .req_word  (req_word),
        .req_idx   (req_idx),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .wen_lo    (wen_lo),
        .wen_hi    (wen_hi),
        .ren_lo    (ren_lo),
        .ren_hi    (ren_hi)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) begin
            m_valid[i] = 0; m_half[i] = 0; m_upper[i] = 0;
            m_lo[i] = '0;   m_hi[i] = '0;
        end
    endtask

    // One request; expectations derived from the requirement text.
    task automatic access(input logic [1:0] op, input logic src, input logic word,
                          input int idx, input logic [63:0] data, input logic en,
                          input string extra);
        string       tag;
        logic [3:0]  exp_en;      // {wen_lo, wen_hi, ren_lo, ren_hi}
        logic [63:0] exp_rd;
        bit          narrow;
        bit          ph;
        narrow = (data[63:32] == 32'h0);
        exp_en = 4'b0000;
        exp_rd = '0;
        ph     = 0;
        if (!en || op == 2'b11) begin
            tag = "R10";
        end else if (op == 2'b00) begin
            if (!m_valid[idx]) begin
                tag = "R1";
            end else if (!m_half[idx] && !m_upper[idx]) begin
                tag = "R3"; exp_en = 4'b0011; exp_rd = {m_hi[idx], m_lo[idx]};
            end else if (m_half[idx]) begin
                tag = "R5";
                if (m_upper[idx]) begin exp_en = 4'b0001; exp_rd = {32'h0, m_hi[idx]}; end
                else              begin exp_en = 4'b0010; exp_rd = {32'h0, m_lo[idx]}; end
            end else begin
                tag = "R7";
                if (src)       begin exp_en = 4'b0011; exp_rd = {m_hi[idx], m_lo[idx]}; end
                else if (word) begin exp_en = 4'b0001; exp_rd = {32'h0, m_hi[idx]}; end
                else           begin exp_en = 4'b0010; exp_rd = {32'h0, m_lo[idx]}; end
            end
        end else if (op == 2'b10) begin
            tag = "R9"; exp_en = 4'b1100;
        end else if (!narrow) begin
            tag = "R2"; exp_en = 4'b1100;
        end else if (!m_valid[idx] || (!m_half[idx] && !m_upper[idx])) begin
            tag = "R4"; ph = word;
        end else if (m_half[idx]) begin
            tag = "R6"; ph = !m_upper[idx];
        end else begin
            tag = "R8"; ph = word;
        end
        if (en && op == 2'b01 && narrow) exp_en = ph ? 4'b0100 : 4'b1000;
        tag = {tag, extra};

        @(negedge clk);
        req_valid = en; req_op = op; req_src = src; req_word = word;
        req_idx = idx[2:0]; wr_data = data;
        #1;
        chk(tag, "half enables", {60'h0, wen_lo, wen_hi, ren_lo, ren_hi}, {60'h0, exp_en});

        // model update
        if (en && op == 2'b10) begin
            m_valid[idx] = 1; m_half[idx] = 0; m_upper[idx] = 1;
            m_lo[idx] = data[31:0]; m_hi[idx] = data[63:32];
        end else if (en && op == 2'b01 && !narrow) begin
            m_valid[idx] = 1; m_half[idx] = 0; m_upper[idx] = 0;
            m_lo[idx] = data[31:0]; m_hi[idx] = data[63:32];
        end else if (en && op == 2'b01) begin
            if (tag.substr(0, 1) == "R4") begin
                m_half[idx] = 1; m_upper[idx] = ph;
            end else begin
                m_half[idx] = 0; m_upper[idx] = 1;
            end
            m_valid[idx] = 1;
            if (ph) m_hi[idx] = data[31:0];
            else    m_lo[idx] = data[31:0];
        end

        @(negedge clk);
        chk({"R11 ", tag}, "rd_valid", {63'h0, rd_valid}, {63'h0, (en && op == 2'b00)});
        if (en && op == 2'b00) chk(tag, "rd_data", rd_data, exp_rd);
        req_valid = 1'b0;
        req_op    = 2'b11;
    endtask

    initial begin : main
        logic [63:0] nar_a, nar_b, wide_v, pair_v;
        int          idx;
        do_reset();
        // R1: reset state
        chk("R1", "rd_valid after reset", {63'h0, rd_valid}, 64'h0);
        for (int i = 0; i < LINES; i++) access(2'b00, 1'b1, 1'b0, i, '0, 1'b1, "");

        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 9; c++) begin
                for (int v = 0; v < 2; v++) begin
                    do_reset();
                    idx    = (s * 3 + c + v) % LINES;
                    nar_a  = v ? 64'h0000_0000_FFFF_FFFF : {32'h0, 32'h1234_0000 + s * 32'h101 + c};
                    nar_b  = {32'h0, 32'h00C0_FFEE ^ (c << 4) ^ (s << 12)};
                    wide_v = v ? 64'h0000_0001_0000_0000 : 64'hDEAD_BEEF_0123_4567 ^ {32'h0, s, c};
                    pair_v = {32'h0000_5A5A + c, 32'h0000_A5A5 + s};
                    // bring line to starting state: 0 empty, 1 wide, 2 half-low, 3 half-high, 4 pair
                    case (s)
                        1: access(2'b01, 1'b0, 1'b0, idx, 64'hFEED_0000_0000_0011, 1'b1, "");
                        2: access(2'b01, 1'b0, 1'b0, idx, nar_a, 1'b1, "");
                        3: access(2'b01, 1'b0, 1'b1, idx, nar_a, 1'b1, "");
                        4: access(2'b10, 1'b1, 1'b0, idx, pair_v, 1'b1, "");
                        default: ;
                    endcase
                    case (c)
                        0: access(2'b00, 1'b0, 1'b0, idx, '0, 1'b1, "");
                        1: access(2'b00, 1'b0, 1'b1, idx, '0, 1'b1, "");
                        2: access(2'b00, 1'b1, 1'b0, idx, '0, 1'b1, "");
                        3: access(2'b01, 1'b0, 1'b0, idx, nar_b, 1'b1, "");
                        4: access(2'b01, 1'b1, 1'b1, idx, nar_b, 1'b1, "");
                        5: access(2'b01, 1'b0, v[0], idx, wide_v, 1'b1, "");
                        6: access(2'b10, 1'b1, 1'b0, idx, wide_v, 1'b1, "");
                        7: access(2'b11, 1'b0, 1'b0, idx, wide_v, 1'b1, "");
                        default: access(2'b01, 1'b0, 1'b1, idx, wide_v, 1'b0, "");
                    endcase
                    // observe resulting line state three ways, and a neighbour line
                    access(2'b00, 1'b1, 1'b0, idx, '0, 1'b1, "");
                    access(2'b00, 1'b0, 1'b0, idx, '0, 1'b1, "");
                    access(2'b00, 1'b0, 1'b1, idx, '0, 1'b1, "");
                    access(2'b00, 1'b1, 1'b0, (idx + 1) % LINES, '0, 1'b1, " R12");
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule